// File: doc/BRIEF.md
# I2C Master Start/Stop Sequencer

The block is the control core of an I2C bus controller. Software writes a command as four control bits in one write: master, transmit, busy and pending. One combination, with the bus free, makes the block generate a START condition. It then shifts out the address-and-direction byte held in its data register and samples the acknowledge on the ninth clock. At the end of that clock it raises an interrupt and holds SCL low. A second combination, written while the block owns the bus, sends a STOP condition. If another device stretches SCL, the STOP waits until SCL is released.

A line monitor synchronises SCL and SDA through two flops and detects START and STOP conditions from any master, which gives the bus-busy status. When the block is not the master it listens to the first byte after a START. If the seven address bits equal its own address, it copies the direction bit into the transmit flag. As master, the transmit flag is set by the START command and is updated after an acknowledged address. In free-data-format mode the first byte is plain data and hardware leaves the transmit flag alone.

The master state machine has seven states:
- `M_IDLE` goes to `M_START` on an accepted START command.
- `M_START` goes to `M_BIT_LO` after one half-period.
- `M_BIT_LO` goes to `M_BIT_HI` after one half-period.
- `M_BIT_HI` goes back to `M_BIT_LO`, or to `M_HOLD` after the ninth bit. It does so once SCL has been seen high for one half-period.
- `M_HOLD` goes to `M_STOP_LO` on a STOP command.
- `M_STOP_LO` goes to `M_STOP_HI` after one half-period.
- `M_STOP_HI` goes to `M_IDLE` once SCL has been seen high for one half-period, releasing SDA.

Top module: `i2cs_ctrl`

## Requirements
- R1: A START begins only when the bus-busy output is 0, the machine is idle, and a single control write has master, transmit, busy and pending all at 1. Any other combination, or a START write while the bus is busy, leaves SCL and SDA undriven and the master flag at 0.
- R2: With ack-enable at 0, a START command is ignored: no line is driven and the master flag stays 0.
- R3: The byte in the data register goes out MSB first. Address bits A6..A0 go on SCL clocks 1 to 7, the direction bit (data bit 0) on clock 8, and SDA is held steady while SCL is high.
- R4: On clock 9 the master releases SDA and samples it at the end of the high phase. The nack output shows the sampled level (1 = not acknowledged).
- R5: The interrupt output rises in the same cycle that SCL is pulled low at the end of clock 9 and is 0 before that. A control write with pending at 1 clears it.
- R6: In the hold state, a control write with master, transmit and pending at 1 and busy at 0 produces a STOP. SDA is driven low while SCL is low, SCL is released, then SDA is released. The master flag and bus-busy then return to 0.
- R7: If SCL is held low by another device during a STOP, SDA stays driven low until SCL is released, and the STOP follows after that.
- R8: Bus-busy is set when SDA falls while SCL is high and cleared when SDA rises while SCL is high, whoever drives the lines. It appears on the third clock edge counting the one that first samples the change.
- R9: As master, after an acknowledged address (nack 0) the transmit flag becomes 1 for direction 0 and 0 for direction 1. After a non-acknowledged address it keeps the value 1 set by the START command.
- R10: When not master, if the seven bits after a START equal the own-address input, the transmit flag takes the direction bit (8th bit). A different address leaves it unchanged, and the block never drives the lines.
- R11: With free-data-format at 1, the transmit flag is not changed after the first byte, in either role.
- R12: After reset, SCL and SDA are undriven, and bus-busy, master flag, transmit flag, nack and interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_mst | input | 1 | Control master bit |
| ctrl_trx | input | 1 | Control transmit bit |
| ctrl_bb | input | 1 | Control busy bit |
| ctrl_pin | input | 1 | Control pending bit (1 clears interrupt) |
| ack_en | input | 1 | Acknowledge enable, needed for START |
| free_fmt | input | 1 | Free-data-format mode |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 8 | Address and direction byte |
| own_addr | input | 7 | Own slave address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| bus_busy | output | 1 | Bus-busy status |
| is_master | output | 1 | Block owns the bus |
| xmit | output | 1 | Transmit flag |
| nack | output | 1 | Acknowledge level sampled on clock 9 |
| irq | output | 1 | Interrupt request |

## Verification
The bus-busy output is checked on every clock against a model in the bench. The model keeps a history of line levels and applies the three-edge delay of R8, so each START or STOP is expected exactly on its third edge. The interrupt, nack and transmit flag are due in the same cycle that SCL falls after the ninth rise, and the bench samples them at that falling line sample. The interrupt clear is checked one cycle after its write. Slave-side flag updates and STOP completion are checked after a fixed wait or by polling against a cycle bound, since they depend on the stretched SCL timing.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        M_IDLE,
        M_START,
        M_BIT_LO,
        M_BIT_HI,
        M_HOLD,
        M_STOP_LO,
        M_STOP_HI
    } mstate_t;
endpackage

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic bus_busy
);
    logic [SYNC-1:0] scl_ff, sda_ff;
    logic            sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            sda_prev <= 1'b1;
            bus_busy <= 1'b0;
        end else begin
            scl_ff   <= {scl_ff[SYNC-2:0], scl_i};
            sda_ff   <= {sda_ff[SYNC-2:0], sda_i};
            sda_prev <= sda_ff[SYNC-1];
            if (start_det)
                bus_busy <= 1'b1;
            else if (stop_det)
                bus_busy <= 1'b0;
        end
    end

    assign scl_s     = scl_ff[SYNC-1];
    assign sda_s     = sda_ff[SYNC-1];
    assign start_det = scl_s & sda_prev & ~sda_s;
    assign stop_det  = scl_s & ~sda_prev & sda_s;

    // R8: bus-busy follows detected conditions
    a_r8_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);
    a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy);
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          free_fmt,
    input  logic [AW-1:0] own_addr,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          hit,
    output logic          hit_dir
);
    localparam int CW = $clog2(AW + 1);

    logic          scl_prev, active;
    logic [CW-1:0] cnt;
    logic [AW-1:0] sh;
    logic          rise;

    assign rise = scl_s & ~scl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            active   <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
            hit      <= 1'b0;
            hit_dir  <= 1'b0;
        end else begin
            scl_prev <= scl_s;
            hit      <= 1'b0;
            if (start_det) begin
                active <= enable;
                cnt    <= '0;
            end else if (stop_det || !enable) begin
                active <= 1'b0;
            end else if (rise && active) begin
                if (cnt == CW'(AW)) begin
                    active  <= 1'b0;
                    hit     <= !free_fmt && (sh == own_addr);
                    hit_dir <= sda_s;
                end else begin
                    sh  <= {sh[AW-2:0], sda_s};
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R11: no address hit in free-data-format mode
    a_r11_free_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        free_fmt |=> !hit);
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl #(
    parameter int HALF_CNT = 4,
    parameter int AW       = 7,
    parameter int SYNC     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          ctrl_mst,
    input  logic          ctrl_trx,
    input  logic          ctrl_bb,
    input  logic          ctrl_pin,
    input  logic          ack_en,
    input  logic          free_fmt,
    input  logic          data_wr,
    input  logic [AW:0]   data_in,
    input  logic [AW-1:0] own_addr,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          bus_busy,
    output logic          is_master,
    output logic          xmit,
    output logic          nack,
    output logic          irq
);
    import i2cs_pkg::*;

    localparam int CW    = $clog2(HALF_CNT + 1);
    localparam int NBITS = AW + 1;
    localparam int BW    = $clog2(NBITS + 1);

    mstate_t        state_q, state_d;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  bitn;
    logic [AW:0]    tx;
    logic           scl_s, sda_s, start_det, stop_det;
    logic           hit, hit_dir;
    logic           half_done, start_cmd, stop_cmd, hi_done, last_bit;

    i2cs_line_mon #(.SYNC(SYNC)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det),
        .stop_det(stop_det), .bus_busy(bus_busy)
    );

    i2cs_addr_match #(.AW(AW)) u_match (
        .clk(clk), .rst_n(rst_n), .enable(!is_master), .free_fmt(free_fmt),
        .own_addr(own_addr), .scl_s(scl_s), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det),
        .hit(hit), .hit_dir(hit_dir)
    );

    assign half_done = (cnt == CW'(HALF_CNT - 1));
    assign hi_done   = scl_s && half_done;
    assign last_bit  = (bitn == BW'(NBITS));
    assign start_cmd = ctrl_wr && ctrl_mst && ctrl_trx && ctrl_bb && ctrl_pin
                       && ack_en && !bus_busy && (state_q == M_IDLE);
    assign stop_cmd  = ctrl_wr && ctrl_mst && ctrl_trx && !ctrl_bb && ctrl_pin
                       && is_master && (state_q == M_HOLD);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE:    if (start_cmd) state_d = M_START;
            M_START:   if (half_done) state_d = M_BIT_LO;
            M_BIT_LO:  if (half_done) state_d = M_BIT_HI;
            M_BIT_HI:  if (hi_done)   state_d = last_bit ? M_HOLD : M_BIT_LO;
            M_HOLD:    if (stop_cmd)  state_d = M_STOP_LO;
            M_STOP_LO: if (half_done) state_d = M_STOP_HI;
            M_STOP_HI: if (hi_done)   state_d = M_IDLE;
            default:                  state_d = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bitn      <= '0;
            tx        <= '0;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
            is_master <= 1'b0;
            xmit      <= 1'b0;
            nack      <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (data_wr) tx <= data_in;

            if (state_d != state_q || state_q == M_IDLE || state_q == M_HOLD)
                cnt <= '0;
            else if (state_q != M_BIT_HI && state_q != M_STOP_HI || scl_s)
                cnt <= cnt + 1'b1;

            scl_oe <= (state_d == M_BIT_LO) || (state_d == M_HOLD) ||
                      (state_d == M_STOP_LO);

            if (ctrl_wr && ctrl_pin) irq <= 1'b0;

            unique case (state_q)
                M_IDLE: begin
                    if (start_cmd) begin
                        sda_oe    <= 1'b1;
                        is_master <= 1'b1;
                        xmit      <= ctrl_trx;
                        bitn      <= '0;
                    end else if (hit) begin
                        xmit <= hit_dir;
                    end
                end
                M_START: ;
                M_BIT_LO: begin
                    if (cnt == '0)
                        sda_oe <= last_bit ? 1'b0 : ~tx[AW - int'(bitn)];
                end
                M_BIT_HI: begin
                    if (hi_done) begin
                        if (last_bit) begin
                            nack <= sda_s;
                            irq  <= 1'b1;
                            if (!sda_s && !free_fmt) xmit <= ~tx[0];
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end
                end
                M_HOLD:    if (stop_cmd) sda_oe <= 1'b1;
                M_STOP_LO: ;
                M_STOP_HI: begin
                    if (hi_done) begin
                        sda_oe    <= 1'b0;
                        is_master <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: mastership only taken on a free bus
    a_r1_start_on_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_master) |-> $past(!bus_busy));
    // R3: SDA steady while the master's SCL is high
    a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_BIT_HI && $past(state_q) == M_BIT_HI) |-> $stable(sda_oe));
    // R5: interrupt rises only with SCL held low
    a_r5_irq_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> scl_oe);
    // R7: SDA held low while SCL is stretched during STOP
    a_r7_stop_waits_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_STOP_HI && !scl_s) |=> sda_oe);
    // R10: a non-master never drives the lines
    a_r10_slave_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2cs_ctrl_bench.sv
module i2cs_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctrl_wr = 0, ctrl_mst = 0, ctrl_trx = 0, ctrl_bb = 0, ctrl_pin = 0;
    logic ack_en = 0, free_fmt = 0, data_wr = 0;
    logic [7:0] data_in = '0;
    logic [6:0] own_addr = 7'h2C;
    logic scl_oe, sda_oe, bus_busy, is_master, xmit, nack, irq;
    logic tb_scl_low = 0, tb_sda_low = 0, resp_low = 0;
    wire  scl_bus = !(scl_oe | tb_scl_low);
    wire  sda_bus = !(sda_oe | tb_sda_low | resp_low);

    int n_tests = 0, n_fail = 0;
    logic hscl [0:4], hsda [0:4];
    logic exp_busy = 0, pscl = 1, psda = 1, ack_on = 1, byte_done = 0, done = 0;
    int   rcnt = 10;
    logic [7:0] rbyte = '0;

    i2cs_ctrl u_i2cs_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_mst(ctrl_mst),
        .ctrl_trx(ctrl_trx), .ctrl_bb(ctrl_bb), .ctrl_pin(ctrl_pin),
        .ack_en(ack_en), .free_fmt(free_fmt), .data_wr(data_wr),
        .data_in(data_in), .own_addr(own_addr), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .bus_busy(bus_busy),
        .is_master(is_master), .xmit(xmit), .nack(nack), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    // Reference model and responder, sampled a quarter period after negedge
    initial for (int i = 0; i < 5; i++) begin hscl[i] = 1; hsda[i] = 1; end
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        for (int i = 4; i > 0; i--) begin hscl[i] = hscl[i-1]; hsda[i] = hsda[i-1]; end
        hscl[0] = scl_bus; hsda[0] = sda_bus;
        if (!rst_n) exp_busy = 0;
        else begin
            if (hscl[3] && hsda[4] && !hsda[3]) exp_busy = 1;
            else if (hscl[3] && !hsda[4] && hsda[3]) exp_busy = 0;
            chk("R8 busy per clock", bus_busy, exp_busy);
        end
        if (pscl && scl_bus && psda && !sda_bus) rcnt = 0;
        else if (!pscl && scl_bus) begin
            if (rcnt < 8) rbyte = {rbyte[6:0], sda_bus};
            rcnt++;
        end else if (pscl && !scl_bus && is_master) begin
            if (rcnt == 8) begin
                chk("R5 irq low before clock 9 ends", irq, 0);
                resp_low = ack_on;
            end else if (rcnt == 9) begin
                resp_low = 0;
                chk("R5 irq at end of clock 9", irq, 1);
                byte_done = 1;
                rcnt = 10;
            end
        end
        pscl = scl_bus; psda = sda_bus;
    end

    task automatic wr_ctrl(logic m, logic t, logic b, logic p);
        @(negedge clk);
        ctrl_wr = 1; ctrl_mst = m; ctrl_trx = t; ctrl_bb = b; ctrl_pin = p;
        @(negedge clk);
        ctrl_wr = 0; ctrl_mst = 0; ctrl_trx = 0; ctrl_bb = 0; ctrl_pin = 0;
    endtask

    task automatic load(logic [7:0] d);
        @(negedge clk); data_wr = 1; data_in = d;
        @(negedge clk); data_wr = 0;
    endtask

    task automatic master_byte(logic [7:0] d, logic ack, logic exp_x, logic exp_n);
        load(d);
        ack_on = ack; byte_done = 0;
        wr_ctrl(1, 1, 1, 1);
        wait (byte_done);
        chk("R3 byte on bus", rbyte, d);
        chk("R4 nack sampled", nack, exp_n);
        chk("R9 R11 xmit after address", xmit, exp_x);
        chk("R1 master after start", is_master, 1);
        wr_ctrl(1, 0, 1, 1);
        chk("R5 irq cleared by pending write", irq, 0);
    endtask

    task automatic wait_free();
        for (int i = 0; i < 200 && bus_busy; i++) @(negedge clk);
        chk("R6 bus free after stop", bus_busy, 0);
        chk("R6 master released", is_master, 0);
        chk("R6 lines undriven", {scl_oe, sda_oe}, 0);
    endtask

    task automatic bm_wait(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bm_bit(logic b);
        tb_sda_low = !b; bm_wait(4);
        tb_scl_low = 0;  bm_wait(8);
        tb_scl_low = 1;  bm_wait(4);
    endtask

    task automatic slave_addr(logic [6:0] a, logic dir, logic exp_x, string req);
        tb_sda_low = 1; bm_wait(8);
        tb_scl_low = 1; bm_wait(4);
        for (int i = 6; i >= 0; i--) bm_bit(a[i]);
        bm_bit(dir);
        bm_bit(1'b1);
        bm_wait(6);
        chk(req, xmit, exp_x);
        chk("R10 no drive as slave", {scl_oe, sda_oe}, 0);
        tb_sda_low = 1; bm_wait(4);
        tb_scl_low = 0; bm_wait(8);
        tb_sda_low = 0; bm_wait(8);
        chk("R8 busy cleared after slave stop", bus_busy, 0);
    endtask

    initial begin
        bm_wait(5);
        rst_n = 1;
        @(negedge clk);
        chk("R12 reset lines", {scl_oe, sda_oe}, 0);
        chk("R12 reset flags", {bus_busy, is_master, xmit, nack, irq}, 0);

        // R2: no acknowledge enable, no start
        load(8'hA5);
        wr_ctrl(1, 1, 1, 1);
        bm_wait(40);
        chk("R2 start ignored without ack enable", {is_master, scl_oe, sda_oe}, 0);

        // R1: partial command patterns ignored
        ack_en = 1;
        wr_ctrl(1, 1, 0, 1);
        wr_ctrl(1, 0, 1, 1);
        bm_wait(20);
        chk("R1 partial command ignored", {is_master, scl_oe, sda_oe}, 0);

        master_byte(8'hA5, 1, 0, 0);      // R9 direction 1 acknowledged
        wr_ctrl(1, 1, 0, 1);
        wait_free();

        master_byte(8'h36, 1, 1, 0);      // R9 direction 0 acknowledged
        wr_ctrl(1, 1, 0, 1);
        wait_free();

        master_byte(8'h6B, 0, 1, 1);      // R4 not acknowledged
        tb_scl_low = 1;                   // R7 stretch during STOP
        wr_ctrl(1, 1, 0, 1);
        bm_wait(30);
        chk("R7 SDA held while SCL stretched", sda_oe, 1);
        chk("R7 no stop while SCL stretched", bus_busy, 1);
        tb_scl_low = 0;
        wait_free();

        free_fmt = 1;                     // R11 master side
        master_byte(8'h55, 1, 1, 0);
        wr_ctrl(1, 1, 0, 1);
        wait_free();
        free_fmt = 0;

        // R1: START refused while another master owns the bus
        tb_sda_low = 1; bm_wait(8);
        wr_ctrl(1, 1, 1, 1);
        bm_wait(10);
        chk("R1 start refused on busy bus", {is_master, scl_oe, sda_oe}, 0);
        chk("R8 busy from foreign start", bus_busy, 1);
        tb_sda_low = 0; bm_wait(10);
        chk("R8 busy cleared by foreign stop", bus_busy, 0);

        slave_addr(7'h2C, 0, 0, "R10 match dir 0");
        slave_addr(7'h2D, 1, 0, "R10 mismatch unchanged");
        slave_addr(7'h2C, 1, 1, "R10 match dir 1");
        free_fmt = 1;
        slave_addr(7'h2C, 0, 1, "R11 free format slave unchanged");
        free_fmt = 0;

        bm_wait(5);
        finish_run();
    end
endmodule